// File: doc/BRIEF.md
# Peripheral Clock Enable and Reset Sequencer

This block decides, for each of 32 peripherals of a system control unit, whether its clock runs and whether it is held in reset. Two 32-bit registers carry that state: a reset-control word, where a 1 keeps the matching peripheral in reset, and a clock-stop word, where a 1 normally stops the matching clock. One bit of the clock-stop word, bit 14, has the opposite sense: setting it starts the clock. Software reads and writes both words through a small register port. A third, read-only word reports which clocks are running, with the polarity of each bit already applied.

Turning a clock on safely is handled by a hardware sequencer. It takes a request that names one peripheral by its clock-stop bit index. If that peripheral has a paired reset line, the sequencer asserts the reset, ungates the clock, waits a settle interval (10 ms by default, taken from the clock frequency parameter), and then releases the reset. A peripheral with no reset line only has its clock ungated. A parameter table gives the pairing. By default, gates 1, 4, 14 and 20 pair with reset bits 7, 10, 14 and 11, and every other gate has no reset. Disabling a clock is an ordinary software write to the clock-stop word.

Top module: `periph_clk_seq`

## Requirements
- R1: After reset every clock enable is low, every peripheral reset line is low, and busy and done are low.
- R2: A write to offset 0x04 loads the reset-control word and a write to 0x0C loads the clock-stop word. A read returns the addressed word on rd_data with rd_valid high in the cycle after the read is accepted. Offset 0x10 returns the clock-running word and any other offset returns 0.
- R3: clk_en[i] is the inverse of clock-stop bit i for every bit except bit 14, where clk_en[14] equals the bit itself. periph_rst[i] equals reset-control bit i.
- R4: For a gate that has a reset bit, take the request accepted at edge A. The paired reset goes high after edge A+1 and the clock runs after edge A+2. The reset is released after edge A+3+SETTLE_CYCLES, and done goes high at that same point.
- R5: For a gate with no reset bit, the clock runs after edge A+1 and done is high in that same cycle. No reset line changes.
- R6: busy is high from the cycle after acceptance until the reset is released, or until the ungate when there is no reset. en_req_ready is low while busy, and a request presented while busy starts nothing.
- R7: done is high for exactly one cycle per completed sequence.
- R8: While a sequence runs, software writes leave the active gate's clock-stop bit and the active reset bit unchanged. All other bits in the same write take effect. After completion those bits are writable again.
- R9: A clock-stop write never changes any reset line.
- R10: The default pairing table maps gate 1 to reset 7, gate 4 to reset 10, gate 14 to reset 14 and gate 20 to reset 11. Every other gate has no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| en_req_valid | input | 1 | Enable sequence request |
| en_req_ready | output | 1 | Sequencer can accept a request |
| en_req_idx | input | 5 | Gate index to enable |
| clk_en | output | 32 | Per-peripheral clock enable |
| periph_rst | output | 32 | Per-peripheral reset, high holds reset |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
Enable requests are applied to a gate with a reset pairing, to a gate without one, and to the inverted-polarity gate 14. Comparing the per-cycle traces of reset, clock, busy and done separates an ordering or off-by-one error in the settle count from a mapping error. All-ones and all-zeros clock-stop writes tell the bit-14 polarity apart from the normal one. A single wide write issued mid-sequence shows that the active bits are locked while their neighbours still change. A second request raised during a sequence must leave its target gate untouched.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 5;
  localparam int ENT_W = IDX_W + 1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic has_rst;
    idx_t rst_bit;
  } map_ent_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_UNGATE,
    SQ_SETTLE,
    SQ_RELEASE
  } seq_st_t;

  // Default gate-to-reset pairing; entries without has_rst mean no reset line.
  function automatic logic [REG_W*ENT_W-1:0] default_rst_map();
    logic [REG_W*ENT_W-1:0] m;
    map_ent_t e;
    m = '0;
    for (int g = 0; g < REG_W; g++) begin
      case (g)
        1:       e = '{has_rst: 1'b1, rst_bit: idx_t'(7)};
        4:       e = '{has_rst: 1'b1, rst_bit: idx_t'(10)};
        14:      e = '{has_rst: 1'b1, rst_bit: idx_t'(14)};
        20:      e = '{has_rst: 1'b1, rst_bit: idx_t'(11)};
        default: e = '{has_rst: 1'b0, rst_bit: '0};
      endcase
      m[g*ENT_W +: ENT_W] = e;
    end
    return m;
  endfunction

  function automatic map_ent_t lookup_ent(logic [REG_W*ENT_W-1:0] m, idx_t g);
    return map_ent_t'(m[int'(g)*ENT_W +: ENT_W]);
  endfunction

  // Running-clock view of the stop word: inverted bits run when set.
  function automatic reg_t stop_to_running(reg_t stop, reg_t inv);
    return stop ^ ~inv;
  endfunction

  // Stop-bit value that makes a gate run.
  function automatic logic run_value(reg_t inv, idx_t g);
    return inv[g];
  endfunction

  function automatic reg_t one_hot(idx_t g);
    return reg_t'(1) << g;
  endfunction
endpackage

// File: rtl/pcs_seq.sv
module pcs_seq
  import pcs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1000000,
  parameter logic [REG_W*ENT_W-1:0] RST_MAP = default_rst_map()
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  idx_t req_idx,
  output logic req_ready,
  output logic busy,
  output logic done,
  output idx_t gidx,
  output idx_t ridx,
  output logic has_rst,
  output logic act_hold,
  output logic act_ungate,
  output logic act_release
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  map_ent_t         ent_q;
  idx_t             gidx_q;
  logic             done_q;
  logic             accept;

  assign busy        = (st_q != SQ_IDLE);
  assign req_ready   = !busy;
  assign accept      = req_valid && req_ready;
  assign act_hold    = (st_q == SQ_HOLD);
  assign act_ungate  = (st_q == SQ_UNGATE);
  assign act_release = (st_q == SQ_RELEASE);
  assign gidx        = gidx_q;
  assign ridx        = ent_q.rst_bit;
  assign has_rst     = ent_q.has_rst;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      ent_q  <= '0;
      gidx_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (act_ungate && !ent_q.has_rst) || act_release;
      case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            gidx_q <= req_idx;
            ent_q  <= lookup_ent(RST_MAP, req_idx);
            st_q   <= lookup_ent(RST_MAP, req_idx).has_rst ? SQ_HOLD : SQ_UNGATE;
          end
        end
        SQ_HOLD:   st_q <= SQ_UNGATE;
        SQ_UNGATE: begin
          if (ent_q.has_rst) begin
            st_q  <= SQ_SETTLE;
            cnt_q <= '0;
          end else begin
            st_q <= SQ_IDLE;
          end
        end
        SQ_SETTLE: begin
          if (cnt_q == CNT_LAST) st_q <= SQ_RELEASE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        SQ_RELEASE: st_q <= SQ_IDLE;
        default:    st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcs_regs.sv
module pcs_regs
  import pcs_pkg::*;
#(
  parameter reg_t INV_MASK = 32'h0000_4000,
  parameter reg_t RST_INIT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_wr,
  input  logic sw_stop_wr,
  input  reg_t wdata,
  input  logic busy,
  input  idx_t gidx,
  input  idx_t ridx,
  input  logic has_rst,
  input  logic act_hold,
  input  logic act_ungate,
  input  logic act_release,
  output reg_t rstctl,
  output reg_t cstop
);
  localparam reg_t STOP_INIT = ~INV_MASK;

  reg_t rstctl_q, cstop_q, rst_nx, stop_nx;
  reg_t lock_stop, lock_rst;

  always_comb begin
    lock_stop = busy ? one_hot(gidx) : '0;
    lock_rst  = (busy && has_rst) ? one_hot(ridx) : '0;

    stop_nx = cstop_q;
    if (sw_stop_wr) stop_nx = (wdata & ~lock_stop) | (cstop_q & lock_stop);
    if (act_ungate) stop_nx[gidx] = run_value(INV_MASK, gidx);

    rst_nx = rstctl_q;
    if (sw_rst_wr) rst_nx = (wdata & ~lock_rst) | (rstctl_q & lock_rst);
    if (act_hold)    rst_nx[ridx] = 1'b1;
    if (act_release) rst_nx[ridx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstctl_q <= RST_INIT;
      cstop_q  <= STOP_INIT;
    end else begin
      rstctl_q <= rst_nx;
      cstop_q  <= stop_nx;
    end
  end

  assign rstctl = rstctl_q;
  assign cstop  = cstop_q;
endmodule

// File: rtl/pcs_bus.sv
module pcs_bus
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RSTCTL_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] CSTOP_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] RUN_OFS    = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  reg_t              reg_wdata,
  input  reg_t              rstctl,
  input  reg_t              cstop,
  input  reg_t              running,
  output logic              sw_rst_wr,
  output logic              sw_stop_wr,
  output reg_t              wdata,
  output logic              rd_valid,
  output reg_t              rd_data
);
  logic rd_acc;
  reg_t rd_mux;
  logic rd_valid_q;
  reg_t rd_data_q;

  assign sw_rst_wr  = reg_valid && reg_write && (reg_addr == RSTCTL_OFS);
  assign sw_stop_wr = reg_valid && reg_write && (reg_addr == CSTOP_OFS);
  assign wdata      = reg_wdata;
  assign rd_acc     = reg_valid && !reg_write;

  always_comb begin
    case (reg_addr)
      RSTCTL_OFS: rd_mux = rstctl;
      CSTOP_OFS:  rd_mux = cstop;
      RUN_OFS:    rd_mux = running;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_acc;
      if (rd_acc) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/periph_clk_seq.sv
module periph_clk_seq
  import pcs_pkg::*;
#(
  parameter int   CLK_HZ        = 100000000,
  parameter int   SETTLE_CYCLES = CLK_HZ / 100,
  parameter reg_t INV_MASK      = 32'h0000_4000,
  parameter reg_t RST_INIT      = '0,
  parameter logic [REG_W*ENT_W-1:0] RST_MAP = default_rst_map(),
  parameter int   ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] RSTCTL_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] CSTOP_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] RUN_OFS    = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  input  logic              en_req_valid,
  output logic              en_req_ready,
  input  logic [IDX_W-1:0]  en_req_idx,
  output logic [REG_W-1:0]  clk_en,
  output logic [REG_W-1:0]  periph_rst,
  output logic              seq_busy,
  output logic              seq_done
);
  // Internal events, named for the checker.
  idx_t seq_gidx, seq_ridx;
  logic seq_has_rst, seq_hold_evt, seq_ungate_evt, seq_release_evt;
  logic sw_rst_wr, sw_stop_wr;
  reg_t wdata, rstctl, cstop, running;

  assign reg_ready  = 1'b1;
  assign running    = stop_to_running(cstop, INV_MASK);
  assign clk_en     = running;
  assign periph_rst = rstctl;

  pcs_seq #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .RST_MAP      (RST_MAP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (en_req_valid),
    .req_idx    (en_req_idx),
    .req_ready  (en_req_ready),
    .busy       (seq_busy),
    .done       (seq_done),
    .gidx       (seq_gidx),
    .ridx       (seq_ridx),
    .has_rst    (seq_has_rst),
    .act_hold   (seq_hold_evt),
    .act_ungate (seq_ungate_evt),
    .act_release(seq_release_evt)
  );

  pcs_regs #(
    .INV_MASK(INV_MASK),
    .RST_INIT(RST_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst_wr  (sw_rst_wr),
    .sw_stop_wr (sw_stop_wr),
    .wdata      (wdata),
    .busy       (seq_busy),
    .gidx       (seq_gidx),
    .ridx       (seq_ridx),
    .has_rst    (seq_has_rst),
    .act_hold   (seq_hold_evt),
    .act_ungate (seq_ungate_evt),
    .act_release(seq_release_evt),
    .rstctl     (rstctl),
    .cstop      (cstop)
  );

  pcs_bus #(
    .ADDR_W    (ADDR_W),
    .RSTCTL_OFS(RSTCTL_OFS),
    .CSTOP_OFS (CSTOP_OFS),
    .RUN_OFS   (RUN_OFS)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rstctl    (rstctl),
    .cstop     (cstop),
    .running   (running),
    .sw_rst_wr (sw_rst_wr),
    .sw_stop_wr(sw_stop_wr),
    .wdata     (wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pcs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic en_req_valid,
  input reg_t clk_en,
  input reg_t periph_rst,
  input logic seq_busy,
  input logic seq_done,
  input idx_t seq_gidx,
  input idx_t seq_ridx,
  input logic seq_has_rst,
  input logic seq_ungate_evt,
  input logic seq_release_evt,
  input logic sw_stop_wr
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r6_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(en_req_valid));

  a_r4_reset_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ungate_evt && seq_has_rst) |-> periph_rst[seq_ridx]);

  a_r4_clock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    seq_release_evt |-> (clk_en[seq_gidx] && periph_rst[seq_ridx]));

  a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seq_release_evt |=> (!periph_rst[seq_ridx] && seq_done && !seq_busy));

  a_r5_direct_ungate: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ungate_evt && !seq_has_rst) |=> (seq_done && clk_en[seq_gidx]));

  a_r9_stop_write_keeps_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stop_wr && !seq_busy) |=> $stable(periph_rst));

  a_r8_locked_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && sw_stop_wr && !seq_ungate_evt) |=>
      (clk_en[seq_gidx] == $past(clk_en[seq_gidx])));
endmodule

bind periph_clk_seq pcs_checker u_pcs_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .en_req_valid   (en_req_valid),
  .clk_en         (clk_en),
  .periph_rst     (periph_rst),
  .seq_busy       (seq_busy),
  .seq_done       (seq_done),
  .seq_gidx       (seq_gidx),
  .seq_ridx       (seq_ridx),
  .seq_has_rst    (seq_has_rst),
  .seq_ungate_evt (seq_ungate_evt),
  .seq_release_evt(seq_release_evt),
  .sw_stop_wr     (sw_stop_wr)
);

// File: tb/periph_clk_seq_bench.sv
module periph_clk_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam logic [31:0] INV = 32'h0000_4000;
  localparam logic [7:0] A_RST  = 8'h04;
  localparam logic [7:0] A_STOP = 8'h0C;
  localparam logic [7:0] A_RUN  = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write, reg_ready;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, rd_data, clk_en, periph_rst;
  logic        rd_valid, en_req_valid, en_req_ready, seq_busy, seq_done;
  logic [4:0]  en_req_idx;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_clk_seq #(.SETTLE_CYCLES(SETTLE)) u_periph_clk_seq (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .en_req_valid(en_req_valid),
    .en_req_ready(en_req_ready), .en_req_idx(en_req_idx), .clk_en(clk_en),
    .periph_rst(periph_rst), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_valid = 0; reg_write = 0; reg_addr = '0; reg_wdata = '0;
    en_req_valid = 0; en_req_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    check(rd_valid === 1'b1, req, {31'b0, rd_valid}, 32'h1);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check(clk_en === 32'h0, "R1 clk_en", clk_en, 32'h0);
    check(periph_rst === 32'h0, "R1 periph_rst", periph_rst, 32'h0);
    check({seq_busy, seq_done} === 2'b00, "R1 busy/done", {30'b0, seq_busy, seq_done}, 32'h0);
    check(en_req_ready === 1'b1, "R6 ready idle", {31'b0, en_req_ready}, 32'h1);
  endtask

  // R2, R3: register map and polarity
  task automatic t_regs();
    do_reset();
    reg_rd(A_STOP, ~INV, "R2 stop reset value");
    reg_wr(A_STOP, 32'h0);
    check(clk_en === ~INV, "R3 all-zero stop", clk_en, ~INV);
    reg_wr(A_STOP, 32'hFFFF_FFFF);
    check(clk_en === INV, "R3 all-one stop", clk_en, INV);
    reg_rd(A_RUN, INV, "R2 running word");
    reg_wr(A_RST, 32'hA5A5_0F0F);
    check(periph_rst === 32'hA5A5_0F0F, "R3 reset lines", periph_rst, 32'hA5A5_0F0F);
    reg_rd(A_RST, 32'hA5A5_0F0F, "R2 reset word readback");
    reg_rd(A_STOP, 32'hFFFF_FFFF, "R2 stop word readback");
    reg_rd(8'h08, 32'h0, "R2 unmapped offset");
  endtask

  // R4, R6, R7, R10: full sequence; optional second request while busy
  task automatic t_seq_rst(input logic [4:0] g, input int r, input bit inject);
    logic [3:0] got, exp;
    bit stop_run_val;
    do_reset();
    stop_run_val = INV[g];
    @(negedge clk);
    en_req_valid = 1; en_req_idx = g;
    @(negedge clk);
    en_req_valid = 0;
    for (int j = 1; j <= SETTLE + 6; j++) begin
      if (inject && j == 5) begin
        check(en_req_ready === 1'b0, "R6 ready low while busy", {31'b0, en_req_ready}, 32'h0);
        en_req_valid = 1; en_req_idx = 5'd20;
      end
      if (inject && j == 6) en_req_valid = 0;
      exp = {(j <= SETTLE + 3), (j == SETTLE + 4), (j >= 3), (j >= 2 && j <= SETTLE + 3)};
      got = {seq_busy, seq_done, clk_en[g], periph_rst[r]};
      check(got === exp, "R4 busy/done/clk/rst trace (R7, R10)", {28'b0, got}, {28'b0, exp});
      @(negedge clk);
    end
    reg_rd(A_STOP, stop_run_val ? 32'hFFFF_FFFF : ~(INV | (32'h1 << g)), "R3 stop bit after enable");
    if (inject) begin
      check(clk_en[20] === 1'b0, "R6 refused request gate", {31'b0, clk_en[20]}, 32'h0);
      check(periph_rst === 32'h0, "R6 refused request reset", periph_rst, 32'h0);
    end
  endtask

  // R5: gate without reset
  task automatic t_seq_norst(input logic [4:0] g);
    logic [2:0] got, exp;
    do_reset();
    reg_wr(A_RST, 32'h0000_0100);
    @(negedge clk);
    en_req_valid = 1; en_req_idx = g;
    @(negedge clk);
    en_req_valid = 0;
    for (int j = 1; j <= 5; j++) begin
      exp = {(j == 1), (j == 2), (j >= 2)};
      got = {seq_busy, seq_done, clk_en[g]};
      check(got === exp, "R5 busy/done/clk trace", {29'b0, got}, {29'b0, exp});
      check(periph_rst === 32'h0000_0100, "R5 resets untouched", periph_rst, 32'h0000_0100);
      @(negedge clk);
    end
  endtask

  // R8, R9: lock during sequence, disable leaves resets alone
  task automatic t_lock();
    do_reset();
    reg_wr(A_STOP, ~32'h20);       // gate 5 running, gate 14 running
    reg_wr(A_RST, 32'h80);         // reset line 7 held
    @(negedge clk);
    en_req_valid = 1; en_req_idx = 5'd4;
    @(negedge clk);
    en_req_valid = 0;
    repeat (4) @(negedge clk);
    reg_wr(A_STOP, 32'hFFFF_BFFF);
    check(clk_en[4] === 1'b1, "R8 locked gate stays on", {31'b0, clk_en[4]}, 32'h1);
    check({clk_en[5], clk_en[14]} === 2'b00, "R8 other gates follow write",
          {30'b0, clk_en[5], clk_en[14]}, 32'h0);
    check(periph_rst === 32'h480, "R9 stop write keeps resets", periph_rst, 32'h480);
    reg_wr(A_RST, 32'h0);
    check(periph_rst === 32'h400, "R8 locked reset held", periph_rst, 32'h400);
    for (int k = 0; k < 100; k++) begin
      if (seq_done) break;
      @(negedge clk);
    end
    check(periph_rst === 32'h0, "R8 reset released after lock", periph_rst, 32'h0);
    reg_wr(A_STOP, 32'hFFFF_FFFF);
    check(clk_en === INV, "R8 gate writable after completion", clk_en, INV);
    check(periph_rst === 32'h0, "R9 disable keeps resets", periph_rst, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_seq_rst(5'd1, 7, 1'b0);
    t_seq_rst(5'd4, 10, 1'b1);
    t_seq_rst(5'd14, 14, 1'b0);
    t_seq_rst(5'd20, 11, 1'b0);
    t_seq_norst(5'd9);
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule